// File: doc/BRIEF.md
# Multi-Core Synchronization Point Unit

This unit coordinates a group of processor cores through a small bank of synchronization points. Each point is a saturating counter. Every core presents one command per cycle: a valid bit, a 2-bit opcode and a point index. Increment and decrement commands change the addressed counter. When several cores address the same point in one cycle, their commands are summed into a single net change.

A sleep command parks the issuing core while the addressed counter is nonzero. All cores parked on a point are released together in the cycle that point's counter reaches zero. A no-op command marks an event and leaves all state unchanged. Cores that run the same code use this to fall back into lockstep. A producer and a consumer use it to hand work to each other.

The unit drives two per-core outputs:
- A stall output, suitable for gating a core's clock. It rises in the cycle the sleep is issued.
- A registered sleeping-status vector.

A sticky flag records any counter that tried to go above its maximum or below zero.

Top module: `sync_unit`

## Requirements
- R1: After reset every counter is zero, no core is sleeping, `stall` is low and `sat_err` is low.
- R2: Opcode encoding per core is 2'b00 no-op, 2'b01 increment, 2'b10 decrement and 2'b11 sleep. An increment adds one to the addressed counter and a decrement subtracts one, and the new value takes effect at the next clock edge.
- R3: All increments and decrements that address one point in the same cycle are applied together at the next edge as a single net change.
- R4: A sleep command whose point counter is nonzero after this cycle's net change raises that core's `stall` combinationally in the issue cycle. From the next edge it sets `sleeping` for that core, which holds until release.
- R5: A sleep command whose point counter is zero after this cycle's net change does not stall the core, and does not set `sleeping`.
- R6: In the cycle a point's counter becomes zero, every core sleeping on that point is released at the same edge.
- R7: A no-op never stalls, changes no counter and wakes no core.
- R8: Commands presented by a core that is sleeping are ignored.
- R9: A counter saturates at its maximum (15 by default) and at zero instead of wrapping. Any such saturation sets `sat_err`, which stays set until reset.
- R10: Commands on one point neither change another point's counter nor wake cores sleeping on another point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NCORES | Per-core command valid |
| cmd_op | input | 2*NCORES | Per-core opcode; core c uses bits [2c+1:2c] |
| cmd_idx | input | IDX_W*NCORES | Per-core point index; core c uses bits [IDX_W*c +: IDX_W] |
| stall | output | NCORES | Per-core stall / clock-gate request, including the issue cycle of a stalling sleep |
| sleeping | output | NCORES | Registered per-core sleeping status |
| sat_err | output | 1 | Sticky saturation error flag |

## Verification
The assertions check four properties on every cycle:
- A sleeping core's point is never zero.
- A core only wakes when its point reads zero.
- The error flag never clears once set.
- With no active command, every counter holds.

Only the directed scenarios can show the rest, because each of these depends on the history of counter values:
- Whether the net change of simultaneous commands is the right amount.
- Whether all sleepers on a point leave together while sleepers on other points stay.
- Whether saturation clamps rather than wraps.
- Whether commands from parked cores are really dropped.

// File: rtl/sync_unit.sv
module sync_unit #(
  parameter int NCORES  = 4,
  parameter int NPOINTS = 8,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = (NPOINTS > 1) ? $clog2(NPOINTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORES-1:0]       cmd_valid,
  input  logic [2*NCORES-1:0]     cmd_op,
  input  logic [IDX_W*NCORES-1:0] cmd_idx,
  output logic [NCORES-1:0]       stall,
  output logic [NCORES-1:0]       sleeping,
  output logic                    sat_err
);

  localparam logic [1:0] OP_INC   = 2'b01;
  localparam logic [1:0] OP_DEC   = 2'b10;
  localparam logic [1:0] OP_SLEEP = 2'b11;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic [NPOINTS-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NCORES-1:0][IDX_W-1:0]  wait_q;
  logic [NCORES-1:0]             sleep_q, sleep_d, active, go_sleep;
  logic [NPOINTS-1:0]            ovf, unf;

  assign active = cmd_valid & ~sleep_q;

  always_comb begin
    int s;
    for (int p = 0; p < NPOINTS; p++) begin
      s = int'(cnt_q[p]);
      for (int c = 0; c < NCORES; c++) begin
        if (active[c] && cmd_idx[c*IDX_W +: IDX_W] == IDX_W'(p)) begin
          if (cmd_op[2*c +: 2] == OP_INC) s = s + 1;
          else if (cmd_op[2*c +: 2] == OP_DEC) s = s - 1;
        end
      end
      ovf[p] = (s > CMAX);
      unf[p] = (s < 0);
      if (ovf[p])      cnt_d[p] = CNT_W'(CMAX);
      else if (unf[p]) cnt_d[p] = '0;
      else             cnt_d[p] = CNT_W'(s);
    end
  end

  always_comb begin
    for (int c = 0; c < NCORES; c++) begin
      go_sleep[c] = active[c] && (cmd_op[2*c +: 2] == OP_SLEEP) &&
                    (cnt_d[cmd_idx[c*IDX_W +: IDX_W]] != '0);
      sleep_d[c]  = sleep_q[c] ? (cnt_d[wait_q[c]] != '0) : go_sleep[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sleep_q <= '0;
      wait_q  <= '0;
      sat_err <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sleep_q <= sleep_d;
      sat_err <= sat_err | (|(ovf | unf));
      for (int c = 0; c < NCORES; c++)
        if (go_sleep[c]) wait_q[c] <= cmd_idx[c*IDX_W +: IDX_W];
    end
  end

  assign stall    = sleep_q | go_sleep;
  assign sleeping = sleep_q;

endmodule

// File: rtl/sync_unit_chk.sv
module sync_unit_chk #(
  parameter int NCORES  = 4,
  parameter int NPOINTS = 8,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NCORES-1:0]             cmd_valid,
  input logic [NCORES-1:0]             sleep_q,
  input logic [NCORES-1:0][IDX_W-1:0]  wait_q,
  input logic [NPOINTS-1:0][CNT_W-1:0] cnt_q,
  input logic                          sat_err
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sat_err |=> sat_err) else $error("sticky flag cleared"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((cmd_valid & ~sleep_q) == '0) |=> $stable(cnt_q)) else $error("counter moved without command"); // R7

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    AST_WAKE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $fell(sleep_q[c]) |-> (cnt_q[wait_q[c]] == '0)) else $error("woke on nonzero point"); // R6
    AST_SLEEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) sleep_q[c] |-> (cnt_q[wait_q[c]] != '0)) else $error("asleep on zero point"); // R4
  end

endmodule

bind sync_unit sync_unit_chk #(
  .NCORES(NCORES), .NPOINTS(NPOINTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .sleep_q(sleep_q),
  .wait_q(wait_q), .cnt_q(cnt_q), .sat_err(sat_err)
);

// File: tb/sync_unit_tb_top.sv
module sync_unit_tb_top;
  localparam logic [1:0] NOP = 2'b00, INC = 2'b01, DEC = 2'b10, SLP = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  v;
  logic [7:0]  op;
  logic [11:0] idx;
  logic [3:0]  stall, sleeping;
  logic        sat_err;
  int n_checks = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v), .cmd_op(op), .cmd_idx(idx),
    .stall(stall), .sleeping(sleeping), .sat_err(sat_err)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic clear_cmds();
    v = '0; op = '0; idx = '0;
  endtask

  task automatic set_cmd(int c, logic [1:0] o, int p);
    v[c] = 1'b1;
    op[2*c +: 2] = o;
    idx[3*c +: 3] = 3'(p);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_cmds();
  endtask

  task automatic all_cmd(logic [1:0] o, int p);
    for (int c = 0; c < 4; c++) set_cmd(c, o, p);
  endtask

  task automatic do_reset();
    clear_cmds();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 stall", 32'(stall), 0);
    check("R1 sleeping", 32'(sleeping), 0);
    check("R1 sat_err", 32'(sat_err), 0);
    for (int c = 0; c < 4; c++) set_cmd(c, SLP, c);
    #1 check("R1 counters zero, no stall", 32'(stall), 0);
    tick();
    check("R1 no sleeper", 32'(sleeping), 0);
  endtask

  task automatic t_sleep_wake();
    do_reset();
    set_cmd(3, INC, 1); tick();
    set_cmd(0, SLP, 1); set_cmd(1, SLP, 1); set_cmd(2, SLP, 1);
    #1 check("R4 stall in issue cycle", 32'(stall), 32'h7);
    check("R4 sleeping registered", 32'(sleeping), 0);
    tick();
    check("R4 sleeping set", 32'(sleeping), 32'h7);
    set_cmd(0, DEC, 1); tick();
    check("R8 command from sleeper ignored", 32'(sleeping), 32'h7);
    set_cmd(3, DEC, 1);
    #1 check("R2 stall held", 32'(stall), 32'h7);
    tick();
    check("R6 all released together", 32'(sleeping), 0);
    check("R6 stall released", 32'(stall), 0);
    check("R2 no error", 32'(sat_err), 0);
  endtask

  task automatic t_sleep_zero();
    do_reset();
    set_cmd(2, SLP, 5);
    #1 check("R5 no stall on zero", 32'(stall), 0);
    tick();
    check("R5 not sleeping", 32'(sleeping), 0);
    set_cmd(1, INC, 5); set_cmd(2, SLP, 5);
    #1 check("R4 same-cycle increment counts", 32'(stall), 32'h4);
    tick();
    check("R4 sleeping", 32'(sleeping), 32'h4);
    set_cmd(1, INC, 5); tick();
    set_cmd(0, DEC, 5); set_cmd(1, DEC, 5); set_cmd(3, SLP, 5);
    #1 check("R5 sleep on point reaching zero proceeds", 32'(stall), 32'h4);
    tick();
    check("R6 released at zero", 32'(sleeping), 0);
  endtask

  task automatic t_net();
    do_reset();
    set_cmd(0, INC, 2); set_cmd(1, INC, 2); set_cmd(2, DEC, 2); set_cmd(3, INC, 2);
    tick();
    set_cmd(0, SLP, 2);
    #1 check("R3 net positive", 32'(stall), 32'h1);
    tick();
    set_cmd(1, DEC, 2); tick();
    check("R3 net was two, still asleep", 32'(sleeping), 32'h1);
    set_cmd(1, DEC, 2); tick();
    check("R3 net was two, now awake", 32'(sleeping), 0);
    check("R3 no error", 32'(sat_err), 0);
  endtask

  task automatic t_snop_indep();
    do_reset();
    set_cmd(3, INC, 4); tick();
    set_cmd(1, NOP, 4);
    #1 check("R7 no-op never stalls", 32'(stall), 0);
    tick();
    set_cmd(0, SLP, 4); tick();
    check("R7 no-op left counter", 32'(sleeping), 32'h1);
    set_cmd(1, NOP, 4); set_cmd(2, NOP, 4); tick();
    check("R7 no-op wakes nobody", 32'(sleeping), 32'h1);
    set_cmd(2, INC, 6); tick();
    check("R10 other point increment", 32'(sleeping), 32'h1);
    set_cmd(1, DEC, 6); tick();
    check("R10 other point to zero", 32'(sleeping), 32'h1);
    set_cmd(3, DEC, 4); tick();
    check("R10 own point wakes", 32'(sleeping), 0);
    check("R10 no error", 32'(sat_err), 0);
  endtask

  task automatic t_sat();
    do_reset();
    set_cmd(0, DEC, 7); tick();
    check("R9 underflow flag", 32'(sat_err), 1);
    set_cmd(0, SLP, 7);
    #1 check("R9 underflow clamped at zero", 32'(stall), 0);
    tick();
    do_reset();
    repeat (3) begin all_cmd(INC, 3); tick(); end
    check("R9 no flag at 12", 32'(sat_err), 0);
    all_cmd(INC, 3); tick();
    check("R9 overflow flag", 32'(sat_err), 1);
    repeat (3) begin all_cmd(DEC, 3); tick(); end
    set_cmd(0, DEC, 3); set_cmd(1, DEC, 3); tick();
    set_cmd(3, SLP, 3);
    #1 check("R9 clamped at max, one left", 32'(stall), 32'h8);
    tick();
    check("R9 flag sticky", 32'(sat_err), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    clear_cmds();
    @(negedge clk);
    t_reset();
    t_sleep_wake();
    t_sleep_zero();
    t_net();
    t_snop_indep();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule